// File: doc/BRIEF.md
# Secure Memory Zone Access Checker

This block sits beside the storage arrays of a small secure memory and rules on every access before it reaches them. The memory is split into three zones: a data zone of sixteen 32-byte slots, an 88-byte configuration zone spread over three 32-byte blocks, and a one-time-programmable (OTP) zone of two blocks. Each request names the zone, a block, a 4-byte word within the block, a direction, and whether it moves one word or a whole 32-byte block. One clock later the block answers with grant or deny. Malformed addresses are also flagged as errors.

The checker keeps the two lock flags, for the configuration zone and the OTP zone, together with the two mode bytes that shape the rules. The OTP mode byte picks how the OTP zone behaves once locked. The selector mode byte decides whether a selector byte may be rewritten freely or only while it still holds zero. A third request kind asks whether such a selector update is allowed. The mode bytes live in the configuration zone, so they can only be loaded while that zone is unlocked. Locking goes configuration first, then OTP.

Top module: `mem_zone_guard`

## Requirements
- R1: A request strobed at a clock edge yields, one edge later, a response lasting one cycle in which exactly one of grant and deny is high. No response appears without a request.
- R2: An address error (deny plus error) results from any of these: zone code 3, op code 3, a data block above 15, a configuration block above 2, an OTP block above 1, or a configuration access whose last word lies past byte 87. The last word is word 7 of the block for a 32-byte access, otherwise the given word, so words 6 and 7 of block 2 and any 32-byte access to block 2 are errors.
- R3: A 32-byte access (req_bulk=1) whose word offset is not zero is denied without an error.
- R4: Any well-formed data zone access (zone code 0) is granted.
- R5: Configuration zone (code 1) reads are always granted. Writes touching words 0 to 3 of block 0 (bytes 0 to 15, identity and reserved bytes) are always denied, including a 32-byte write to block 0.
- R6: A configuration write at word index 4 or above (block*8+word) is granted only while the configuration lock is clear.
- R7: While the OTP lock is clear, every well-formed OTP access (zone code 2) is granted.
- R8: With the OTP lock set and OTP mode 0xAA, OTP writes are denied and OTP reads are granted.
- R9: With the OTP lock set and OTP mode 0x00, OTP writes are denied, every 32-byte read is denied, 4-byte reads of block 0 words 0 and 1 are denied, and other 4-byte reads are granted.
- R10: With the OTP lock set and any OTP mode other than 0xAA or 0x00, every OTP access is denied.
- R11: A selector update request (op code 2, address fields ignored) is granted when the selector mode byte is zero, and otherwise only when sel_cur is zero.
- R12: A lock pulse with lock_otp=0 sets the configuration lock. With lock_otp=1 it sets the OTP lock only if the configuration lock is already set, and is otherwise ignored. Locks clear only on reset, and reset clears both and loads OTP mode 0xAA and selector mode 0x00.
- R13: A mode load (mode_wr) takes effect only while the configuration lock is clear, and once that lock is set it is ignored. Op codes: 0 read, 1 write, 2 selector update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | 0 read, 1 write, 2 selector update, 3 reserved |
| req_zone | input | 2 | 0 data, 1 configuration, 2 OTP, 3 invalid |
| req_block | input | 4 | Block or slot number |
| req_word | input | 3 | 4-byte word offset within the block |
| req_bulk | input | 1 | 1 for a 32-byte access, 0 for 4 bytes |
| sel_cur | input | 8 | Present value of the selector byte |
| lock_pulse | input | 1 | Lock request strobe |
| lock_otp | input | 1 | Lock target: 0 configuration, 1 OTP |
| mode_wr | input | 1 | Mode byte load strobe |
| mode_otp_in | input | 8 | OTP mode value to load |
| mode_sel_in | input | 8 | Selector mode value to load |
| rsp_valid | output | 1 | Response present |
| rsp_grant | output | 1 | Access allowed |
| rsp_deny | output | 1 | Access refused |
| rsp_addr_err | output | 1 | Refused because the address is malformed |
| cfg_locked | output | 1 | Configuration lock flag |
| otp_locked | output | 1 | OTP lock flag |

## Verification
Assertions check every cycle that the response follows a strobe by one cycle and that grant, deny and error stay mutually consistent. They also check that both locks are sticky, that the OTP lock never stands without the configuration lock, that mode bytes hold still once configuration is locked, and that no OTP write is granted under a set OTP lock. The finer rules can only be shown by the bench's scenarios, run under chosen lock states and mode values. These are the legacy read masking, the configuration word boundaries, the selector condition and the ignoring of out-of-order lock and late mode loads.

// File: rtl/mzg_pkg.sv
package mzg_pkg;
    localparam int BLK_W  = 4;
    localparam int WORD_W = 3;

    typedef enum logic [1:0] {
        OP_READ   = 2'd0,
        OP_WRITE  = 2'd1,
        OP_SELUPD = 2'd2,
        OP_RSVD   = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        ZN_DATA = 2'd0,
        ZN_CFG  = 2'd1,
        ZN_OTP  = 2'd2,
        ZN_BAD  = 2'd3
    } zone_e;

    localparam logic [7:0] OTPM_READONLY = 8'hAA;
    localparam logic [7:0] OTPM_LEGACY   = 8'h00;

    typedef struct packed {
        op_e               op;
        zone_e             zone;
        logic [BLK_W-1:0]  blk;
        logic [WORD_W-1:0] word;
        logic              bulk;
    } req_t;

    typedef struct packed {
        logic grant;
        logic err;
    } verdict_t;

    function automatic verdict_t mk_verdict(input logic g, input logic e);
        verdict_t v;
        v.grant = g & ~e;
        v.err   = e;
        return v;
    endfunction
endpackage

// File: rtl/mzg_addr_check.sv
module mzg_addr_check
    import mzg_pkg::*;
#(
    parameter int SLOT_CNT   = 16,
    parameter int CFG_BYTES  = 88,
    parameter int OTP_BLOCKS = 2
) (
    input  req_t                    req,
    output logic                    addr_err,
    output logic                    misalign,
    output logic [BLK_W+WORD_W-1:0] first_idx
);
    localparam int WPB        = 1 << WORD_W;
    localparam int IDX_W      = BLK_W + WORD_W;
    localparam int CFG_BLOCKS = (CFG_BYTES + 4*WPB - 1) / (4*WPB);
    localparam int CFG_LAST   = CFG_BYTES/4 - 1;

    logic [IDX_W-1:0] last_idx;
    logic [BLK_W:0]   blk_ext;

    always_comb begin
        blk_ext   = {1'b0, req.blk};
        first_idx = {req.blk, req.word};
        last_idx  = req.bulk ? {req.blk, {WORD_W{1'b1}}} : {req.blk, req.word};
        misalign  = req.bulk && (req.word != '0);
        case (req.zone)
            ZN_DATA: addr_err = (blk_ext >= (BLK_W+1)'(SLOT_CNT));
            ZN_CFG:  addr_err = (blk_ext >= (BLK_W+1)'(CFG_BLOCKS)) ||
                                ({1'b0, last_idx} > (IDX_W+1)'(CFG_LAST));
            ZN_OTP:  addr_err = (blk_ext >= (BLK_W+1)'(OTP_BLOCKS));
            default: addr_err = 1'b1;
        endcase
    end
endmodule

// File: rtl/mzg_lock_regs.sv
module mzg_lock_regs
    import mzg_pkg::*;
#(
    parameter logic [7:0] OTP_MODE_RST = OTPM_READONLY,
    parameter logic [7:0] SEL_MODE_RST = 8'h00
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       lock_pulse,
    input  logic       lock_otp,
    input  logic       mode_wr,
    input  logic [7:0] mode_otp_in,
    input  logic [7:0] mode_sel_in,
    output logic       cfg_locked,
    output logic       otp_locked,
    output logic [7:0] otp_mode,
    output logic [7:0] sel_mode
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_locked <= 1'b0;
            otp_locked <= 1'b0;
            otp_mode   <= OTP_MODE_RST;
            sel_mode   <= SEL_MODE_RST;
        end else begin
            if (lock_pulse && !lock_otp)
                cfg_locked <= 1'b1;
            if (lock_pulse && lock_otp && cfg_locked)
                otp_locked <= 1'b1;
            if (mode_wr && !cfg_locked) begin
                otp_mode <= mode_otp_in;
                sel_mode <= mode_sel_in;
            end
        end
    end

    AST_CFG_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
        cfg_locked |=> cfg_locked); // R12
    AST_OTP_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
        otp_locked |=> otp_locked); // R12
    AST_LOCK_ORDER: assert property (@(posedge clk) disable iff (rst)
        otp_locked |-> cfg_locked); // R12
    AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (rst)
        cfg_locked |=> ($stable(otp_mode) && $stable(sel_mode))); // R13
endmodule

// File: rtl/mzg_rule_eval.sv
module mzg_rule_eval
    import mzg_pkg::*;
#(
    parameter int CFG_FIXED_WORDS = 4
) (
    input  req_t                    req,
    input  logic                    addr_err,
    input  logic                    misalign,
    input  logic [BLK_W+WORD_W-1:0] first_idx,
    input  logic                    cfg_locked,
    input  logic                    otp_locked,
    input  logic [7:0]              otp_mode,
    input  logic [7:0]              sel_mode,
    input  logic [7:0]              sel_cur,
    output verdict_t                verdict
);
    localparam int IDX_W = BLK_W + WORD_W;

    logic g, e;

    always_comb begin
        g = 1'b0;
        e = 1'b0;
        if (req.op == OP_SELUPD) begin
            g = (sel_mode == 8'h00) || (sel_cur == 8'h00);
        end else if (req.op == OP_RSVD || addr_err) begin
            e = 1'b1;
        end else if (!misalign) begin
            case (req.zone)
                ZN_DATA: g = 1'b1;
                ZN_CFG: begin
                    if (req.op == OP_READ)
                        g = 1'b1;
                    else
                        g = !cfg_locked && ({1'b0, first_idx} >= (IDX_W+1)'(CFG_FIXED_WORDS));
                end
                ZN_OTP: begin
                    if (!otp_locked)
                        g = 1'b1;
                    else if (req.op == OP_WRITE)
                        g = 1'b0;
                    else if (otp_mode == OTPM_READONLY)
                        g = 1'b1;
                    else if (otp_mode == OTPM_LEGACY)
                        g = !req.bulk && !(req.blk == '0 && req.word < WORD_W'(2));
                    else
                        g = 1'b0;
                end
                default: e = 1'b1;
            endcase
        end
        verdict = mk_verdict(g, e);
    end
endmodule

// File: rtl/mem_zone_guard.sv
module mem_zone_guard
    import mzg_pkg::*;
#(
    parameter int SLOT_CNT   = 16,
    parameter int CFG_BYTES  = 88,
    parameter int OTP_BLOCKS = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  logic [1:0] req_op,
    input  logic [1:0] req_zone,
    input  logic [3:0] req_block,
    input  logic [2:0] req_word,
    input  logic       req_bulk,
    input  logic [7:0] sel_cur,
    input  logic       lock_pulse,
    input  logic       lock_otp,
    input  logic       mode_wr,
    input  logic [7:0] mode_otp_in,
    input  logic [7:0] mode_sel_in,
    output logic       rsp_valid,
    output logic       rsp_grant,
    output logic       rsp_deny,
    output logic       rsp_addr_err,
    output logic       cfg_locked,
    output logic       otp_locked
);
    req_t                    req;
    logic                    addr_err, misalign;
    logic [BLK_W+WORD_W-1:0] first_idx;
    logic [7:0]              otp_mode, sel_mode;
    verdict_t                verdict;

    assign req = '{op: op_e'(req_op), zone: zone_e'(req_zone),
                   blk: req_block, word: req_word, bulk: req_bulk};

    mzg_addr_check #(.SLOT_CNT(SLOT_CNT), .CFG_BYTES(CFG_BYTES), .OTP_BLOCKS(OTP_BLOCKS)) u_addr (
        .req(req), .addr_err(addr_err), .misalign(misalign), .first_idx(first_idx));

    mzg_lock_regs u_lock (
        .clk(clk), .rst(rst), .lock_pulse(lock_pulse), .lock_otp(lock_otp),
        .mode_wr(mode_wr), .mode_otp_in(mode_otp_in), .mode_sel_in(mode_sel_in),
        .cfg_locked(cfg_locked), .otp_locked(otp_locked),
        .otp_mode(otp_mode), .sel_mode(sel_mode));

    mzg_rule_eval u_rule (
        .req(req), .addr_err(addr_err), .misalign(misalign), .first_idx(first_idx),
        .cfg_locked(cfg_locked), .otp_locked(otp_locked), .otp_mode(otp_mode),
        .sel_mode(sel_mode), .sel_cur(sel_cur), .verdict(verdict));

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid    <= 1'b0;
            rsp_grant    <= 1'b0;
            rsp_deny     <= 1'b0;
            rsp_addr_err <= 1'b0;
        end else begin
            rsp_valid    <= req_valid;
            rsp_grant    <= req_valid && verdict.grant;
            rsp_deny     <= req_valid && !verdict.grant;
            rsp_addr_err <= req_valid && verdict.err;
        end
    end

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid); // R1
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid); // R1
    AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $countones({rsp_grant, rsp_deny}) == 1); // R1
    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> !(rsp_grant || rsp_deny || rsp_addr_err)); // R1
    AST_ERR_DENIES: assert property (@(posedge clk) disable iff (rst)
        rsp_addr_err |-> rsp_deny); // R2
    AST_OTP_LOCKED_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == 2'd1 && req_zone == 2'd2 && otp_locked) |=> !rsp_grant); // R8
endmodule

// File: tb/mem_zone_guard_tb.sv
module mem_zone_guard_tb_top;
    logic       clk = 1'b0;
    logic       rst;
    logic       req_valid;
    logic [1:0] req_op, req_zone;
    logic [3:0] req_block;
    logic [2:0] req_word;
    logic       req_bulk;
    logic [7:0] sel_cur;
    logic       lock_pulse, lock_otp, mode_wr;
    logic [7:0] mode_otp_in, mode_sel_in;
    logic       rsp_valid, rsp_grant, rsp_deny, rsp_addr_err, cfg_locked, otp_locked;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit m_cfg, m_otp;
    logic [7:0] m_omode, m_smode;

    always #2.5 clk = ~clk;

    mem_zone_guard dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op), .req_zone(req_zone),
        .req_block(req_block), .req_word(req_word), .req_bulk(req_bulk), .sel_cur(sel_cur),
        .lock_pulse(lock_pulse), .lock_otp(lock_otp), .mode_wr(mode_wr),
        .mode_otp_in(mode_otp_in), .mode_sel_in(mode_sel_in), .rsp_valid(rsp_valid),
        .rsp_grant(rsp_grant), .rsp_deny(rsp_deny), .rsp_addr_err(rsp_addr_err),
        .cfg_locked(cfg_locked), .otp_locked(otp_locked));

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b (valid,grant,deny,err)", tag, act, exp);
        end
    endtask

    // expected {grant, err} plus the requirement tag it exercises
    function automatic logic [1:0] expect_rule(input logic [1:0] op, input logic [1:0] zn,
            input logic [3:0] b, input logic [2:0] w, input logic bk, input logic [7:0] sc,
            output string tag);
        int last;
        tag = "R4";
        if (op == 2) begin
            tag = "R11";
            return {(m_smode == 0) || (sc == 0), 1'b0};
        end
        last = b*8 + (bk ? 7 : w);
        if (op == 3 || zn == 3 || (zn == 1 && (b > 2 || last > 21)) || (zn == 2 && b > 1)) begin
            tag = "R2";
            return 2'b01;
        end
        if (bk && w != 0) begin
            tag = "R3";
            return 2'b00;
        end
        if (zn == 0) return 2'b10;
        if (zn == 1) begin
            if (op == 0) begin tag = "R5"; return 2'b10; end
            if (b*8 + w < 4) begin tag = "R5"; return 2'b00; end
            tag = "R6";
            return {!m_cfg, 1'b0};
        end
        if (!m_otp) begin tag = "R7"; return 2'b10; end
        if (m_omode == 8'hAA) begin tag = "R8"; return {op == 0, 1'b0}; end
        if (m_omode == 8'h00) begin
            tag = "R9";
            return {op == 0 && !bk && !(b == 0 && w < 2), 1'b0};
        end
        tag = "R10";
        return 2'b00;
    endfunction

    // one cycle: inputs driven at negedge, response checked at the next negedge
    task automatic step(input bit v, input logic [1:0] op, input logic [1:0] zn,
            input logic [3:0] b, input logic [2:0] w, input logic bk, input logic [7:0] sc,
            input bit lp, input bit lo, input bit mw, input logic [7:0] om, input logic [7:0] sm);
        logic [1:0] e;
        string tag;
        req_valid = v; req_op = op; req_zone = zn; req_block = b; req_word = w;
        req_bulk = bk; sel_cur = sc; lock_pulse = lp; lock_otp = lo; mode_wr = mw;
        mode_otp_in = om; mode_sel_in = sm;
        e = expect_rule(op, zn, b, w, bk, sc, tag);
        @(posedge clk);
        if (lp && !lo) m_cfg = 1;
        if (lp && lo && m_cfg) m_otp = 1;
        if (mw && !m_cfg) begin m_omode = om; m_smode = sm; end
        @(negedge clk);
        if (v) chk(tag, {rsp_valid, rsp_grant, rsp_deny, rsp_addr_err}, {1'b1, e[1], !e[1], e[0]});
        else   chk("R1", {rsp_valid, rsp_grant, rsp_deny, rsp_addr_err}, 4'b0000);
    endtask

    task automatic req(input logic [1:0] op, input logic [1:0] zn, input logic [3:0] b,
            input logic [2:0] w, input logic bk);
        step(1, op, zn, b, w, bk, 8'h00, 0, 0, 0, 8'h00, 8'h00);
    endtask

    task automatic rand_reqs(input int n);
        for (int i = 0; i < n; i++) begin
            logic [7:0] sc;
            sc = ($urandom % 3 == 0) ? 8'h00 : 8'($urandom);
            step(($urandom % 5) != 0, 2'($urandom), 2'($urandom), 4'($urandom % 5),
                 3'($urandom), 1'($urandom), sc, 0, 0, 0, 8'h00, 8'h00);
        end
    endtask

    task automatic do_reset;
        rst = 1;
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 8'h00, 8'h00);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 8'h00, 8'h00);
        rst = 0;
        m_cfg = 0; m_otp = 0; m_omode = 8'hAA; m_smode = 8'h00;
        chk("R12", {2'b00, cfg_locked, otp_locked}, 4'b0000);
    endtask

    task automatic set_modes(input logic [7:0] om, input logic [7:0] sm);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, om, sm);
    endtask

    task automatic lock(input bit lo);
        step(0, 0, 0, 0, 0, 0, 0, 1, lo, 0, 8'h00, 8'h00);
    endtask

    initial begin
        while (cycles < 150000) begin
            @(posedge clk);
            cycles++;
        end
        failures++;
        $display("FAIL watchdog expired at cycle %0d", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        do_reset();
        // unlocked: boundaries of configuration and OTP addressing
        req(1, 1, 2, 5, 0);            // R6 word 21 writable while unlocked
        req(0, 1, 2, 6, 0);            // R2 byte 88
        req(0, 1, 2, 0, 1);            // R2 bulk block 2
        req(1, 1, 0, 3, 0);            // R5 fixed bytes
        req(1, 1, 0, 0, 1);            // R5 bulk over fixed bytes
        req(0, 0, 0, 4, 1);            // R3 misaligned bulk
        req(1, 2, 0, 0, 1);            // R7
        req(0, 3, 0, 0, 0);            // R2 zone 3
        step(1, 2, 3, 0, 0, 0, 8'h05, 0, 0, 0, 0, 0); // R11 mode 0
        rand_reqs(300);
        // legacy mode, locking order
        set_modes(8'h00, 8'h01);
        lock(1);                       // ignored: configuration not yet locked
        chk("R12", {2'b00, cfg_locked, otp_locked}, 4'b0000);
        lock(0);
        chk("R12", {2'b00, cfg_locked, otp_locked}, 4'b0010);
        set_modes(8'hAA, 8'h00);       // ignored after configuration lock (R13)
        step(1, 2, 0, 0, 0, 0, 8'h03, 0, 0, 0, 0, 0); // R11/R13 selector mode stays 1
        step(1, 2, 0, 0, 0, 0, 8'h00, 0, 0, 0, 0, 0); // R11 selector zero
        req(1, 1, 1, 0, 0);            // R6 locked write denied
        lock(1);
        chk("R12", {2'b00, cfg_locked, otp_locked}, 4'b0011);
        req(0, 2, 0, 1, 0);            // R9 word 1 hidden
        req(0, 2, 0, 2, 0);            // R9 word 2 readable
        req(0, 2, 1, 0, 1);            // R9 bulk read denied; R13 mode not changed to 0xAA
        rand_reqs(400);
        // read-only mode
        do_reset();
        lock(0);
        lock(1);
        req(0, 2, 0, 0, 1);            // R8 bulk read granted
        req(1, 2, 1, 3, 0);            // R8 write denied
        rand_reqs(300);
        // unsupported mode
        do_reset();
        set_modes(8'h55, 8'h00);
        lock(0);
        lock(1);
        req(0, 2, 1, 4, 0);            // R10
        rand_reqs(300);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule